// File: doc/BRIEF.md
# Response Ring Writer

This block takes 64-bit response records from a codec link receiver and stores each one as an 8-byte entry in a 256-entry ring held in system memory. Every record is a 32-bit response word plus a 32-bit extended word. Bits 3:0 of the extended word carry the codec address the response came from, and bit 4 marks the response as unsolicited. The block keeps a hardware write pointer that always names the last entry written. It paces the response interrupt with a programmable entry count. It also flags an overrun when software has not yet freed the slot the next record would occupy.

Software programs the block through a small register port. Registers are chosen by a 3-bit select:

| Select | Register |
|---|---|
| 0 | ring base |
| 1 | write pointer |
| 2 | interrupt count |
| 3 | control |
| 4 | status |
| 5 | size |

Software reports how far it has consumed the ring on `sw_rd_ptr`, which holds the index of the last entry it has read. The global unsolicited-enable bit from the controller's global control arrives on `unsol_en`.

A three-state sequencer does the work:

- `ST_IDLE` holds `rsp_ready` high and decides the fate of each record on the cycle it is accepted. It stays in `ST_IDLE` when the record is discarded or overruns. It moves to `ST_WR_LO` when the record is kept.
- `ST_WR_LO` writes the response word and always moves to `ST_WR_HI`.
- `ST_WR_HI` writes the extended word, commits the write pointer and the response count, and returns to `ST_IDLE`.

Top module: `rsp_ring_writer`

## Requirements
- R1: After reset the pointer reads 0, status reads 0, control reads 0, interrupt count reads 0, size reads 0x02 and `irq` is low.
- R2: A kept record goes to slot s = (pointer + 1) mod 256. The response word is written at byte address base + 8*s and the extended word at base + 8*s + 4. After the commit the pointer reads s. The base register ignores its low 11 bits, which read as 0.
- R3: A write to the pointer register with bit 15 set makes the pointer 0. A write without bit 15 leaves it unchanged. A bit-15 write in the same cycle as a commit still leaves the pointer at 0.
- R4: A record with extended bit 4 set while `unsol_en` is low is discarded. It causes no memory write and does not change the pointer, status or count. A record with bit 4 clear is kept regardless of `unsol_en`, and both words are stored unaltered.
- R5: While control bit 1 (DMA enable) is 0, every record is accepted and discarded, and the response counter is held at zero.
- R6: Status bit 0 sets on the commit of the N-th kept record since the last time it was raised, or since DMA was last disabled. N is the interrupt count register (bits 7:0), and a value of 0 means 256.
- R7: If the slot a kept record would use equals `sw_rd_ptr`, the record is dropped: no memory write, the pointer is unchanged, and status bit 2 sets.
- R8: Writing 1s to status clears the matching bits, and 0x05 clears both. When a set and a clear of the same bit fall in one cycle, the set wins.
- R9: `irq` = (status bit 0 AND control bit 0) OR (status bit 2 AND control bit 2).
- R10: Writes to the size register are ignored, and it always reads 0x02 (256 entries).
- R11: `rsp_ready` is high only in `ST_IDLE`. The two memory writes of one record fall in consecutive cycles, the response word first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_valid | input | 1 | Response record present |
| rsp_ready | output | 1 | Block can take a record this cycle |
| rsp_word | input | 32 | Response word |
| rsp_ext | input | 32 | Extended word: bits 3:0 codec address, bit 4 unsolicited |
| unsol_en | input | 1 | Global unsolicited-response enable |
| sw_rd_ptr | input | 8 | Last ring index consumed by software |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (codes in the table above) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| irq | output | 1 | Response or overrun interrupt |

## Verification
A record's commit in `ST_WR_HI` can set status bit 0 in the same cycle that software writes 1 to clear it. The bench provokes this by timing the clear so it lands exactly on the commit edge, two cycles after acceptance. It then judges the result by reading status, where the bit must still be set. A bit-15 pointer reset is aimed at the commit edge in the same way, and the pointer must read 0 while the record still lands in memory at its slot.

// File: rtl/rrw_pkg.sv
package rrw_pkg;

    // register select codes
    localparam logic [2:0] SEL_BASE = 3'd0;
    localparam logic [2:0] SEL_WPTR = 3'd1;
    localparam logic [2:0] SEL_ICNT = 3'd2;
    localparam logic [2:0] SEL_CTRL = 3'd3;
    localparam logic [2:0] SEL_STAT = 3'd4;
    localparam logic [2:0] SEL_SIZE = 3'd5;

    localparam int REG_W        = 32;
    localparam int WPTR_RST_BIT = 15;
    localparam int UNSOL_BIT    = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WR_LO = 2'd1,
        ST_WR_HI = 2'd2
    } wr_state_e;

    // size-register encoding for a ring of 2**ptr_w entries
    function automatic logic [1:0] size_code(input int ptr_w);
        if (ptr_w == 8)      return 2'd2;
        else if (ptr_w == 4) return 2'd1;
        else                 return 2'd0;
    endfunction

endpackage

// File: rtl/rrw_pace.sv
module rrw_pace #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic             dma_en,
    input  logic [PTR_W-1:0] icnt,
    output logic             hit
);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(1 << PTR_W);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] thr;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        thr     = (icnt == '0) ? FULL_CNT : CNT_W'(icnt);
        cnt_inc = cnt_q + 1'b1;
        hit     = commit && (cnt_inc >= thr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (!dma_en) cnt_q <= '0;
        else if (hit)     cnt_q <= '0;
        else if (commit)  cnt_q <= cnt_inc;
    end
endmodule

// File: rtl/rrw_regs.sv
module rrw_regs
    import rrw_pkg::*;
#(
    parameter int PTR_W  = 8,
    parameter int ADDR_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_we,
    input  logic [2:0]                reg_sel,
    input  logic [REG_W-1:0]          reg_wdata,
    output logic [REG_W-1:0]          reg_rdata,
    input  logic                      rint_set,
    input  logic                      ovr_set,
    input  logic [PTR_W-1:0]          wptr,
    output logic [ADDR_W-PTR_W-4:0]   base_hi,
    output logic [PTR_W-1:0]          icnt,
    output logic                      dma_en,
    output logic                      wptr_clr,
    output logic                      stat_rint,
    output logic                      stat_ovr,
    output logic                      irq
);
    localparam int ALIGN = PTR_W + 3;
    localparam int HI_W  = ADDR_W - ALIGN;
    localparam logic [1:0] SIZE_VAL = size_code(PTR_W);

    logic       rint_en_q, dma_en_q, ovr_en_q;
    logic       stat_clr;
    logic [HI_W-1:0] base_q;
    logic [PTR_W-1:0] icnt_q;
    logic       rint_q, ovr_q;
    logic       unused_wdata;

    assign stat_clr = reg_we && (reg_sel == SEL_STAT);
    assign wptr_clr = reg_we && (reg_sel == SEL_WPTR) && reg_wdata[WPTR_RST_BIT];
    assign unused_wdata = ^{reg_wdata};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            icnt_q    <= '0;
            rint_en_q <= 1'b0;
            dma_en_q  <= 1'b0;
            ovr_en_q  <= 1'b0;
        end else if (reg_we) begin
            case (reg_sel)
                SEL_BASE: base_q <= reg_wdata[ALIGN +: HI_W];
                SEL_ICNT: icnt_q <= reg_wdata[PTR_W-1:0];
                SEL_CTRL: begin
                    rint_en_q <= reg_wdata[0];
                    dma_en_q  <= reg_wdata[1];
                    ovr_en_q  <= reg_wdata[2];
                end
                default: ;
            endcase
        end
    end

    // status: set wins over write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rint_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (rint_set)                      rint_q <= 1'b1;
            else if (stat_clr && reg_wdata[0]) rint_q <= 1'b0;
            if (ovr_set)                       ovr_q  <= 1'b1;
            else if (stat_clr && reg_wdata[2]) ovr_q  <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_BASE: reg_rdata = REG_W'({base_q, {ALIGN{1'b0}}});
            SEL_WPTR: reg_rdata = REG_W'(wptr);
            SEL_ICNT: reg_rdata = REG_W'(icnt_q);
            SEL_CTRL: reg_rdata = REG_W'({ovr_en_q, dma_en_q, rint_en_q});
            SEL_STAT: reg_rdata = REG_W'({ovr_q, 1'b0, rint_q});
            SEL_SIZE: reg_rdata = REG_W'(SIZE_VAL);
            default:  reg_rdata = '0;
        endcase
    end

    assign base_hi   = base_q;
    assign icnt      = icnt_q;
    assign dma_en    = dma_en_q;
    assign stat_rint = rint_q;
    assign stat_ovr  = ovr_q;
    assign irq       = (rint_q && rint_en_q) || (ovr_q && ovr_en_q);
endmodule

// File: rtl/rrw_seq.sv
module rrw_seq
    import rrw_pkg::*;
#(
    parameter int PTR_W  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rsp_valid,
    output logic                    rsp_ready,
    input  logic [DATA_W-1:0]       rsp_word,
    input  logic [DATA_W-1:0]       rsp_ext,
    input  logic                    unsol_en,
    input  logic [PTR_W-1:0]        sw_rd_ptr,
    input  logic                    dma_en,
    input  logic [ADDR_W-PTR_W-4:0] base_hi,
    input  logic                    wptr_clr,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    output logic                    commit,
    output logic                    ovr_set,
    output logic [PTR_W-1:0]        wptr
);
    wr_state_e state_q, state_d;

    logic [DATA_W-1:0] word_q, ext_q;
    logic [PTR_W-1:0]  slot_q, wptr_q, next_slot;
    logic              accept, keep, full;

    always_comb begin
        next_slot = wptr_q + 1'b1;
        full      = (next_slot == sw_rd_ptr);
        accept    = rsp_valid && (state_q == ST_IDLE);
        keep      = dma_en && (!rsp_ext[UNSOL_BIT] || unsol_en);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept && keep && !full) state_d = ST_WR_LO;
            ST_WR_LO: state_d = ST_WR_HI;
            ST_WR_HI: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            ext_q  <= '0;
            slot_q <= '0;
        end else if (accept) begin
            word_q <= rsp_word;
            ext_q  <= rsp_ext;
            slot_q <= next_slot;
        end
    end

    // write pointer: software reset wins over a commit
    always_ff @(posedge clk) begin
        if (!rst_n)      wptr_q <= '0;
        else if (wptr_clr) wptr_q <= '0;
        else if (commit) wptr_q <= slot_q;
    end

    // outputs
    always_comb begin
        rsp_ready = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {base_hi, slot_q, 3'b000};
        mem_wdata = word_q;
        commit    = 1'b0;
        ovr_set   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                rsp_ready = 1'b1;
                ovr_set   = accept && keep && full;
            end
            ST_WR_LO: begin
                mem_we = 1'b1;
            end
            ST_WR_HI: begin
                mem_we    = 1'b1;
                mem_addr  = {base_hi, slot_q, 3'b100};
                mem_wdata = ext_q;
                commit    = 1'b1;
            end
            default: ;
        endcase
    end

    assign wptr = wptr_q;
endmodule

// File: rtl/rsp_ring_writer.sv
module rsp_ring_writer
    import rrw_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rsp_valid,
    output logic                     rsp_ready,
    input  logic [DATA_W-1:0]        rsp_word,
    input  logic [DATA_W-1:0]        rsp_ext,
    input  logic                     unsol_en,
    input  logic [$clog2(DEPTH)-1:0] sw_rd_ptr,
    input  logic                     reg_we,
    input  logic [2:0]               reg_sel,
    input  logic [REG_W-1:0]         reg_wdata,
    output logic [REG_W-1:0]         reg_rdata,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    output logic                     irq
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int HI_W  = ADDR_W - PTR_W - 3;

    logic [HI_W-1:0]  base_hi_w;
    logic [PTR_W-1:0] icnt_w, wptr_w;
    logic dma_en_w, wptr_clr_w, commit_w, ovr_set_w, hit_w;
    logic stat_rint_w, stat_ovr_w;

    rrw_regs #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .rint_set(hit_w), .ovr_set(ovr_set_w), .wptr(wptr_w),
        .base_hi(base_hi_w), .icnt(icnt_w), .dma_en(dma_en_w),
        .wptr_clr(wptr_clr_w), .stat_rint(stat_rint_w),
        .stat_ovr(stat_ovr_w), .irq(irq)
    );

    rrw_seq #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_word(rsp_word), .rsp_ext(rsp_ext),
        .unsol_en(unsol_en), .sw_rd_ptr(sw_rd_ptr),
        .dma_en(dma_en_w), .base_hi(base_hi_w), .wptr_clr(wptr_clr_w),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .commit(commit_w), .ovr_set(ovr_set_w), .wptr(wptr_w)
    );

    rrw_pace #(.PTR_W(PTR_W)) pace_i (
        .clk(clk), .rst_n(rst_n),
        .commit(commit_w), .dma_en(dma_en_w), .icnt(icnt_w), .hit(hit_w)
    );
endmodule

// File: rtl/rsp_ring_writer_chk.sv
module rsp_ring_writer_chk #(
    parameter int PTR_W  = 8,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [PTR_W-1:0]  wptr,
    input logic              stat_ovr
);
    // R11
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !rsp_ready);

    // R11
    hi_follows_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_addr[2]) |=> (mem_we && mem_addr == $past(mem_addr) + ADDR_W'(4)));

    // R2
    word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[1:0] == 2'b00));

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr != $past(wptr)) |-> (wptr == PTR_W'($past(wptr) + 1'b1) || wptr == '0));

    // R7
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_ovr) |-> $past(rsp_valid && rsp_ready));
endmodule

bind rsp_ring_writer rsp_ring_writer_chk #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .wptr(wptr_w), .stat_ovr(stat_ovr_w)
);

// File: tb/rsp_ring_writer_tb_top.sv
`timescale 1ns/1ps
module rsp_ring_writer_tb_top;
    localparam logic [31:0] BASE = 32'h0001_2800;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rsp_valid = 1'b0;
    logic rsp_ready;
    logic [31:0] rsp_word = '0, rsp_ext = '0;
    logic unsol_en = 1'b0;
    logic [7:0] sw_rd_ptr = '0;
    logic reg_we = 1'b0;
    logic [2:0] reg_sel = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic irq;

    int checks = 0, errors = 0, wr_count = 0, addr_bad = 0;
    logic [31:0] cap_lo [256];
    logic [31:0] cap_hi [256];
    logic [7:0] exp_wp = 0;
    logic [31:0] rd;
    int wc0;

    always #2.5 clk = ~clk;

    rsp_ring_writer dut_i (
        .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_word(rsp_word), .rsp_ext(rsp_ext), .unsol_en(unsol_en),
        .sw_rd_ptr(sw_rd_ptr), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
    );

    always @(posedge clk) if (rst_n && mem_we) begin
        wr_count <= wr_count + 1;
        if (mem_addr[31:11] != BASE[31:11]) addr_bad <= addr_bad + 1;
        if (mem_addr[2]) cap_hi[mem_addr[10:3]] <= mem_wdata;
        else             cap_lo[mem_addr[10:3]] <= mem_wdata;
    end

    // {word, ext, unsol_en, expected keep}
    localparam int NV = 7;
    localparam logic [65:0] VEC [NV] = '{
        {32'h1234_5678, 32'h0000_0003, 1'b1, 1'b1},
        {32'hCAFE_0001, 32'h0000_0012, 1'b1, 1'b1},
        {32'hDEAD_BEEF, 32'h0000_0015, 1'b0, 1'b0},
        {32'h0BAD_F00D, 32'h0000_0007, 1'b0, 1'b1},
        {32'hFFFF_FFFF, 32'h0000_001F, 1'b0, 1'b0},
        {32'h0000_0000, 32'h0000_000F, 1'b1, 1'b1},
        {32'hA5A5_5A5A, 32'h0000_0011, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rdreg(input logic [2:0] sel, output logic [31:0] d);
        @(negedge clk); reg_sel = sel; #1 d = reg_rdata;
    endtask

    task automatic send(input logic [31:0] w, input logic [31:0] e);
        @(negedge clk); rsp_word = w; rsp_ext = e; rsp_valid = 1'b1;
        @(negedge clk); rsp_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // record whose commit edge coincides with a register write
    task automatic send_race(input logic [31:0] w, input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk); rsp_word = w; rsp_ext = 32'h1; rsp_valid = 1'b1;
        @(negedge clk); rsp_valid = 1'b0;
        chk("R11 ready low while writing", {31'b0, rsp_ready}, 32'h0);
        @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rdreg(3'd1, rd); chk("R1 wptr", rd, 0);
        rdreg(3'd4, rd); chk("R1 status", rd, 0);
        rdreg(3'd3, rd); chk("R1 ctrl", rd, 0);
        rdreg(3'd2, rd); chk("R1 icnt", rd, 0);
        rdreg(3'd5, rd); chk("R1 size", rd, 32'h2);
        chk("R1 irq", {31'b0, irq}, 0);

        wr(3'd0, BASE | 32'h7FF);
        rdreg(3'd0, rd); chk("R2 base low bits zero", rd, BASE);
        wr(3'd2, 32'd1);
        wr(3'd3, 32'h7);

        // table walk: R2 layout, R4 unsolicited filtering, R6 with count 1
        for (int i = 0; i < NV; i++) begin
            unsol_en = VEC[i][1];
            sw_rd_ptr = exp_wp;
            wc0 = wr_count;
            send(VEC[i][65:34], VEC[i][33:2]);
            if (VEC[i][0]) begin
                exp_wp = exp_wp + 1;
                chk("R2 lo word", cap_lo[exp_wp], VEC[i][65:34]);
                chk("R2 hi word", cap_hi[exp_wp], VEC[i][33:2]);
                rdreg(3'd4, rd); chk("R6 status per entry", rd, 32'h1);
            end else begin
                chk("R4 no write", wr_count - wc0, 0);
                rdreg(3'd4, rd); chk("R4 status untouched", rd, 0);
            end
            rdreg(3'd1, rd); chk("R2 R4 wptr", rd, {24'b0, exp_wp});
            wr(3'd4, 32'h5);
        end
        unsol_en = 1'b1;

        // R6 count of 3, R9, R8
        wr(3'd2, 32'd3);
        sw_rd_ptr = exp_wp;
        send(32'h11, 32'h1); send(32'h22, 32'h1);
        exp_wp = exp_wp + 2;
        rdreg(3'd4, rd); chk("R6 not yet after 2", rd, 0);
        chk("R9 irq low", {31'b0, irq}, 0);
        send(32'h33, 32'h1); exp_wp = exp_wp + 1;
        rdreg(3'd4, rd); chk("R6 set after 3", rd, 32'h1);
        chk("R9 irq high", {31'b0, irq}, 1);
        wr(3'd4, 32'h5);
        rdreg(3'd4, rd); chk("R8 cleared", rd, 0);
        chk("R8 irq low after clear", {31'b0, irq}, 0);

        // R5 DMA disable drops and restarts counter
        wr(3'd2, 32'd2);
        send(32'h44, 32'h1); exp_wp = exp_wp + 1;
        wr(3'd3, 32'h5);
        wc0 = wr_count;
        send(32'h55, 32'h1);
        chk("R5 no write when DMA off", wr_count - wc0, 0);
        rdreg(3'd1, rd); chk("R5 wptr kept", rd, {24'b0, exp_wp});
        wr(3'd3, 32'h7);
        sw_rd_ptr = exp_wp;
        send(32'h66, 32'h1); exp_wp = exp_wp + 1;
        rdreg(3'd4, rd); chk("R5 counter restarted", rd, 0);
        send(32'h77, 32'h1); exp_wp = exp_wp + 1;
        rdreg(3'd4, rd); chk("R6 after restart", rd, 32'h1);
        wr(3'd4, 32'h5);

        // R7 overrun
        sw_rd_ptr = exp_wp + 1;
        wc0 = wr_count;
        send(32'h88, 32'h1);
        chk("R7 no write", wr_count - wc0, 0);
        rdreg(3'd1, rd); chk("R7 wptr kept", rd, {24'b0, exp_wp});
        rdreg(3'd4, rd); chk("R7 status bit2", rd, 32'h4);
        chk("R9 overrun irq", {31'b0, irq}, 1);
        wr(3'd3, 32'h3);
        chk("R9 overrun irq masked", {31'b0, irq}, 0);
        wr(3'd4, 32'h5);
        wr(3'd3, 32'h7);

        // R8 set and clear in one cycle
        wr(3'd2, 32'd1);
        sw_rd_ptr = exp_wp;
        send_race(32'h99, 3'd4, 32'h1); exp_wp = exp_wp + 1;
        rdreg(3'd4, rd); chk("R8 set wins over clear", rd, 32'h1);
        wr(3'd4, 32'h5);

        // R3 pointer reset on commit edge
        sw_rd_ptr = exp_wp;
        send_race(32'hAA, 3'd1, 32'h8000);
        chk("R3 record still stored", cap_lo[exp_wp + 8'd1], 32'hAA);
        rdreg(3'd1, rd); chk("R3 reset wins over commit", rd, 0);
        exp_wp = 0;
        wr(3'd4, 32'h5);
        sw_rd_ptr = 0;
        send(32'hBB, 32'h1); exp_wp = 1;
        wr(3'd1, 32'h0000_7FFF);
        rdreg(3'd1, rd); chk("R3 write without bit15 ignored", rd, 1);
        wr(3'd1, 32'h8000);
        rdreg(3'd1, rd); chk("R3 bit15 resets", rd, 0);
        exp_wp = 0;

        // R10 size writes ignored
        wr(3'd5, 32'h1);
        rdreg(3'd5, rd); chk("R10 size fixed", rd, 32'h2);

        // R6 count 0 means 256, and R2 wrap through slot 0
        wr(3'd4, 32'h5);
        wr(3'd2, 32'd0);
        for (int k = 0; k < 255; k++) begin
            sw_rd_ptr = exp_wp;
            send(32'h1000 + k, 32'h1);
            exp_wp = exp_wp + 1;
        end
        rdreg(3'd4, rd); chk("R6 zero count not yet at 255", rd, 0);
        sw_rd_ptr = exp_wp;
        send(32'hF00D, 32'h2);
        exp_wp = exp_wp + 1;
        rdreg(3'd4, rd); chk("R6 zero count at 256", rd, 32'h1);
        rdreg(3'd1, rd); chk("R2 wptr wrapped", rd, 0);
        chk("R2 slot 0 lo", cap_lo[0], 32'hF00D);
        chk("R2 slot 0 hi", cap_hi[0], 32'h2);
        chk("R2 addresses in ring", addr_bad, 0);

        finish_run();
    end
endmodule